// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Register

This block is the status and control register that sits beside a floating-point datapath. At the end of every arithmetic operation the datapath presents a five-bit vector of the exception conditions that operation raised, together with a completion strobe. The register records these conditions in two fields.

- A per-operation field is reloaded on every completion, so it reflects only the latest operation.
- A sticky field collects every condition seen since software last cleared it.

Whenever a completion reports at least one condition, the block compares the sticky field against a software-set enable field. If any bit is set in both, the block issues a one-cycle trap request carrying the fixed vector code 0x120.

Compare operations report their outcome as well. An ordered outcome (equal, greater or less) drives only the compare truth bit and leaves the register alone. An unordered outcome is treated like an arithmetic completion and updates the exception fields.

Software writes the register through a write port, and a writable-bits mask applies to each write. The block decodes two controls for the datapath from the register: round-to-zero versus round-to-nearest-even, and flush of denormals to zero.

Top module: `fpu_status_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is asserted and after it is released, `csr_q` is zero. `trap_req`, `trap_code`, `cmp_t` and `cmp_t_valid` are also zero at that point.
- R2: A write (`wr_en` high) loads `csr_q` with `wr_data & 32'h0005FFFF` at the next clock edge. Bit 17 and bits 31:19 always read zero.
- R3: `rnd_to_zero` is high exactly when `csr_q[1:0]` equals 2'b01, and every other encoding means round-to-nearest-even. `flush_en` equals `csr_q[18]`.
- R4: An operation that takes effect replaces `csr_q[6:2]` with `op_exc`. The bit order of `op_exc` is [4]=invalid, [3]=divide-by-zero, [2]=overflow, [1]=underflow and [0]=inexact.
- R5: When `op_exc` is non-zero, an operation that takes effect ORs `op_exc` into the sticky field `csr_q[16:12]`. When `op_exc` is zero, the sticky field is left as it was. The operation never changes the enable field `csr_q[11:7]`, the rounding field or bit 18.
- R6: `trap_req` pulses high for one cycle, the cycle after a taking-effect operation with a non-zero `op_exc`, if the updated sticky field ANDed with the enable field is non-zero. `trap_code` reads 12'h120 while `trap_req` is high and zero otherwise.
- R7: For a compare (`op_is_cmp` high) with an ordered `cmp_res` (0=equal, 1=greater, 2=less), `csr_q` is unchanged and `cmp_t_valid` pulses for one cycle. `cmp_t` becomes `cmp_res==0` when `cmp_kind` is 0 (equality test), or `cmp_res==1` when `cmp_kind` is 1 (greater-than test).
- R8: A compare with an unordered `cmp_res` (3) updates the register as in R4 to R6. `cmp_t` keeps its value and `cmp_t_valid` stays low.
- R9: When `wr_en` and `op_done` are high in the same cycle, the write wins. The operation, including any compare result, has no effect and raises no trap.
- R10: With neither `op_done` nor `wr_en` high, `csr_q` holds its value and `trap_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_done | input | 1 | Operation completion strobe |
| op_exc | input | 5 | Exception conditions of the completing operation |
| op_is_cmp | input | 1 | Completing operation is a compare |
| cmp_kind | input | 1 | 0 = equality test, 1 = greater-than test |
| cmp_res | input | 2 | Compare outcome: 0 equal, 1 greater, 2 less, 3 unordered |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| csr_q | output | 32 | Register value |
| rnd_to_zero | output | 1 | Round-to-zero selected (else nearest-even) |
| flush_en | output | 1 | Flush denormals to zero |
| cmp_t | output | 1 | Compare truth bit |
| cmp_t_valid | output | 1 | One-cycle pulse when `cmp_t` is updated |
| trap_req | output | 1 | One-cycle exception request |
| trap_code | output | 12 | Exception vector code, 12'h120 with `trap_req` |

## Verification
Every field of the register is visible on `csr_q` one edge after the event that changed it. A wrong per-operation or sticky update therefore shows at the ports on the very next cycle. A sticky bit that is lost or wrongly set stays latent until a later operation's trap decision goes the wrong way. For that reason the sweeps run a full sequence of all 32 exception vectors over each enable pattern without clearing in between, so that a trap caused by earlier history is checked as well as one caused by the current operation. A compare that wrongly touches the register shows on `csr_q` at once, and a wrong truth bit shows on `cmp_t` in the same cycle.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

  localparam int CSR_W    = 32;
  localparam int EXC_W    = 5;
  localparam int RM_W     = 2;
  localparam int RM_LSB   = 0;
  localparam int FLAG_LSB = 2;
  localparam int EN_LSB   = FLAG_LSB + EXC_W;
  localparam int STKY_LSB = EN_LSB + EXC_W;
  localparam int DNRM_BIT = 18;
  localparam int VEC_W    = 12;

  localparam logic [CSR_W-1:0] WR_MASK  = 32'h0005_FFFF;
  localparam logic [RM_W-1:0]  RM_ZERO  = 2'b01;
  localparam logic [VEC_W-1:0] TRAP_VEC = 12'h120;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_GT = 2'd1,
    CMP_LT = 2'd2,
    CMP_UN = 2'd3
  } cmp_res_e;

  function automatic logic [EXC_W-1:0] merge_sticky(input logic [EXC_W-1:0] sticky,
                                                    input logic [EXC_W-1:0] exc);
    merge_sticky = (exc != '0) ? (sticky | exc) : sticky;
  endfunction

  function automatic logic trap_hit_f(input logic [EXC_W-1:0] exc,
                                      input logic [EXC_W-1:0] sticky_new,
                                      input logic [EXC_W-1:0] enable);
    trap_hit_f = (exc != '0) && ((sticky_new & enable) != '0);
  endfunction

  function automatic logic t_eval(input logic kind, input logic [1:0] res);
    t_eval = kind ? (res == CMP_GT) : (res == CMP_EQ);
  endfunction

  function automatic logic [CSR_W-1:0] apply_wmask(input logic [CSR_W-1:0] data);
    apply_wmask = data & WR_MASK;
  endfunction

endpackage

// File: rtl/fpsc_ctrl_decode.sv
module fpsc_ctrl_decode
  import fpsc_pkg::*;
#(
  parameter int RMW = RM_W
) (
  input  logic [RMW-1:0] rm_field,
  input  logic           dn_bit,
  output logic           rnd_to_zero,
  output logic           flush_en
);
  always_comb begin
    rnd_to_zero = (rm_field == RM_ZERO);
    flush_en    = dn_bit;
  end
endmodule

// File: rtl/fpsc_event_unit.sv
module fpsc_event_unit
  import fpsc_pkg::*;
#(
  parameter int EW = EXC_W
) (
  input  logic          op_done,
  input  logic          op_is_cmp,
  input  logic          cmp_kind,
  input  logic [1:0]    cmp_res,
  input  logic          wr_en,
  input  logic [EW-1:0] op_exc,
  input  logic [EW-1:0] sticky_q,
  input  logic [EW-1:0] enable_q,
  output logic          op_takes,
  output logic          cmp_ordered,
  output logic [EW-1:0] flags_next,
  output logic [EW-1:0] sticky_next,
  output logic          trap_hit,
  output logic          t_next
);
  logic live;

  always_comb begin
    live        = op_done && !wr_en;
    cmp_ordered = live && op_is_cmp && (cmp_res != CMP_UN);
    op_takes    = live && !(op_is_cmp && (cmp_res != CMP_UN));
    flags_next  = op_exc;
    sticky_next = merge_sticky(sticky_q, op_exc);
    trap_hit    = op_takes && trap_hit_f(op_exc, sticky_next, enable_q);
    t_next      = t_eval(cmp_kind, cmp_res);
  end
endmodule

// File: rtl/fpsc_trap_pulse.sv
module fpsc_trap_pulse
  import fpsc_pkg::*;
#(
  parameter int VW = VEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  output logic          trap_req,
  output logic [VW-1:0] trap_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req  <= 1'b0;
      trap_code <= '0;
    end else begin
      trap_req  <= hit;
      trap_code <= hit ? TRAP_VEC : '0;
    end
  end
endmodule

// File: rtl/fpu_status_ctrl.sv
module fpu_status_ctrl
  import fpsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_done,
  input  logic [EXC_W-1:0]  op_exc,
  input  logic              op_is_cmp,
  input  logic              cmp_kind,
  input  logic [1:0]        cmp_res,
  input  logic              wr_en,
  input  logic [CSR_W-1:0]  wr_data,
  output logic [CSR_W-1:0]  csr_q,
  output logic              rnd_to_zero,
  output logic              flush_en,
  output logic              cmp_t,
  output logic              cmp_t_valid,
  output logic              trap_req,
  output logic [VEC_W-1:0]  trap_code
);
  logic             op_takes;
  logic             cmp_ordered;
  logic [EXC_W-1:0] flags_next;
  logic [EXC_W-1:0] sticky_next;
  logic             trap_hit;
  logic             t_next;
  logic [CSR_W-1:0] csr_from_op;

  fpsc_event_unit #(.EW(EXC_W)) evt_i (
    .op_done    (op_done),
    .op_is_cmp  (op_is_cmp),
    .cmp_kind   (cmp_kind),
    .cmp_res    (cmp_res),
    .wr_en      (wr_en),
    .op_exc     (op_exc),
    .sticky_q   (csr_q[STKY_LSB +: EXC_W]),
    .enable_q   (csr_q[EN_LSB +: EXC_W]),
    .op_takes   (op_takes),
    .cmp_ordered(cmp_ordered),
    .flags_next (flags_next),
    .sticky_next(sticky_next),
    .trap_hit   (trap_hit),
    .t_next     (t_next)
  );

  always_comb begin
    csr_from_op = csr_q;
    csr_from_op[FLAG_LSB +: EXC_W] = flags_next;
    csr_from_op[STKY_LSB +: EXC_W] = sticky_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q       <= '0;
      cmp_t       <= 1'b0;
      cmp_t_valid <= 1'b0;
    end else begin
      cmp_t_valid <= cmp_ordered;
      if (cmp_ordered) cmp_t <= t_next;
      if (wr_en)         csr_q <= apply_wmask(wr_data);
      else if (op_takes) csr_q <= csr_from_op;
    end
  end

  fpsc_ctrl_decode #(.RMW(RM_W)) dec_i (
    .rm_field   (csr_q[RM_LSB +: RM_W]),
    .dn_bit     (csr_q[DNRM_BIT]),
    .rnd_to_zero(rnd_to_zero),
    .flush_en   (flush_en)
  );

  fpsc_trap_pulse #(.VW(VEC_W)) trp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (trap_hit),
    .trap_req (trap_req),
    .trap_code(trap_code)
  );

  assert_write_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (csr_q == ($past(wr_data) & 32'h0005_FFFF)));

  assert_flag_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_takes |=> (csr_q[FLAG_LSB +: EXC_W] == $past(op_exc)));

  assert_sticky_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (($past(csr_q[STKY_LSB +: EXC_W]) & ~csr_q[STKY_LSB +: EXC_W]) == '0));

  assert_enable_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(csr_q[EN_LSB +: EXC_W]));

  assert_trap_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ($past(op_done) && !$past(wr_en) && ($past(op_exc) != '0)));

  assert_trap_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_code == 12'h120));

  assert_cmp_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ordered |=> ($stable(csr_q) && cmp_t_valid && !trap_req));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_done) |=> (!trap_req && !cmp_t_valid));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_done && !wr_en) |=> ($stable(csr_q) && !trap_req));

endmodule

// File: tb/fpu_status_ctrl_tb.sv
module fpu_status_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_done = 1'b0;
  logic [4:0]  op_exc = '0;
  logic        op_is_cmp = 1'b0;
  logic        cmp_kind = 1'b0;
  logic [1:0]  cmp_res = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] csr_q;
  logic        rnd_to_zero, flush_en, cmp_t, cmp_t_valid, trap_req;
  logic [11:0] trap_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] m_csr = '0;
  logic        m_t = 1'b0;
  logic        m_trap = 1'b0;
  logic        m_tv = 1'b0;

  always #5 clk = ~clk;

  fpu_status_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_exc(op_exc),
    .op_is_cmp(op_is_cmp), .cmp_kind(cmp_kind), .cmp_res(cmp_res),
    .wr_en(wr_en), .wr_data(wr_data), .csr_q(csr_q),
    .rnd_to_zero(rnd_to_zero), .flush_en(flush_en), .cmp_t(cmp_t),
    .cmp_t_valid(cmp_t_valid), .trap_req(trap_req), .trap_code(trap_code)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req,  "csr",   csr_q, m_csr);
    chk("R6", "trap",  {31'd0, trap_req}, {31'd0, m_trap});
    chk("R6", "code",  {20'd0, trap_code}, m_trap ? 32'h120 : 32'h0);
    chk("R7", "t",     {31'd0, cmp_t}, {31'd0, m_t});
    chk("R7", "tv",    {31'd0, cmp_t_valid}, {31'd0, m_tv});
    chk("R3", "rtz",   {31'd0, rnd_to_zero}, {31'd0, (m_csr[1:0] == 2'b01)});
    chk("R3", "flush", {31'd0, flush_en}, {31'd0, m_csr[18]});
  endtask

  task automatic step(input logic wr, input logic [31:0] wd, input logic od,
                      input logic [4:0] ex, input logic cmp, input logic kind,
                      input logic [1:0] res, input string req);
    logic [4:0] stk;
    @(negedge clk);
    wr_en = wr; wr_data = wd; op_done = od; op_exc = ex;
    op_is_cmp = cmp; cmp_kind = kind; cmp_res = res;
    m_trap = 1'b0; m_tv = 1'b0;
    if (wr) begin
      m_csr = wd & 32'h0005_FFFF;
    end else if (od) begin
      if (cmp && res != 2'd3) begin
        m_tv = 1'b1;
        m_t  = kind ? (res == 2'd1) : (res == 2'd0);
      end else begin
        m_csr[6:2] = ex;
        if (ex != 5'd0) begin
          stk = m_csr[16:12] | ex;
          m_csr[16:12] = stk;
          m_trap = ((stk & m_csr[11:7]) != 5'd0);
        end
      end
    end
    @(posedge clk);
    #1;
    check_all(req);
    wr_en = 1'b0; op_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_all("R1");

    // R2: write mask, then all rounding encodings (R3) with denormal bit
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R2");
    for (int rm = 0; rm < 4; rm++) begin
      step(1, 32'h0004_0000 | rm, 0, 0, 0, 0, 0, "R3");
      step(1, rm, 0, 0, 0, 0, 0, "R3");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R10");

    // R4/R5/R6: sweep every exception vector under several enable patterns,
    // sticky history carried across the sweep
    for (int ep = 0; ep < 8; ep++) begin
      logic [4:0] en;
      case (ep)
        0: en = 5'h00; 1: en = 5'h01; 2: en = 5'h02; 3: en = 5'h04;
        4: en = 5'h08; 5: en = 5'h10; 6: en = 5'h15; default: en = 5'h1F;
      endcase
      step(1, {15'd0, en, 7'd0} | 32'h1, 0, 0, 0, 0, 0, "R2");
      for (int e = 0; e < 32; e++) begin
        step(0, 0, 1, e[4:0], 0, 0, 0, (e == 0) ? "R5" : "R4");
        if (e[0]) step(0, 0, 0, 0, 0, 0, 0, "R10");
      end
    end

    // R6: trap from earlier history on an operation whose own bits are not enabled
    step(1, 32'h0000_0400, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 1, 5'h08, 0, 0, 0, "R6");
    step(0, 0, 1, 5'h01, 0, 0, 0, "R6");
    step(0, 0, 1, 5'h00, 0, 0, 0, "R6");

    // R7/R8: compare sweep over kinds, outcomes and reported vectors
    step(1, 32'h0000_0F80, 0, 0, 0, 0, 0, "R2");
    for (int k = 0; k < 2; k++)
      for (int r = 0; r < 4; r++)
        for (int e = 0; e < 32; e += 7)
          step(0, 0, 1, e[4:0], 1, k[0], r[1:0], (r == 3) ? "R8" : "R7");

    // R9: write and completion in the same cycle
    step(1, 32'h0000_0F80, 0, 0, 0, 0, 0, "R2");
    step(1, 32'h0004_0F81, 1, 5'h1F, 0, 0, 0, "R9");
    step(1, 32'h0000_0F80, 1, 5'h10, 1, 0, 2'd3, "R9");
    step(1, 32'h0000_0000, 1, 5'h00, 1, 0, 2'd0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, "R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule